// File: doc/BRIEF.md
# Peripheral-Overridable GPIO Port Controller

This block is an eight-pin general-purpose I/O port with a small register bus. Software owns three registers: a direction register, an output data register and a read-only input register. For each pin, a direction bit of 1 drives the pad from the output data bit, and a bit of 0 leaves the pad undriven.

Peripherals on the chip can take a pin over without software involvement. A timer output-compare channel that is enabled can claim any pin. A PWM channel can claim pins 0, 4 and 5, but only when no timer channel holds that pin. The external clock output can claim pin 5, but only when neither a timer nor a PWM channel holds it. While a peripheral holds a pin, the pin is an output and carries that peripheral's value. The stored direction bit does not change, so software control returns unchanged when the peripheral lets go.

The input register always shows the pad level after a two-flop synchronizer. Software can therefore compare the level it drives with the level the pad actually sits at.

Top module: `gpio_ovr_port`

## Requirements
- R1: After a synchronous active-low reset, the direction and data registers hold 0, every pad_oe bit is 0, and a read of the direction or data offset returns 0.
- R2: The direction register sits at offset 0x242 and can be read back and written at any time. With no override active on a pin, pad_oe for that pin equals its direction bit (1 = output, 0 = input) in the cycle after the write.
- R3: The output data register sits at offset 0x240 and reads back what was written. For a pin with direction 1 and no override, pad_out equals the data bit.
- R4: A read at offset 0x241 returns pad_in delayed by two clock edges, whatever the pin's direction or override state. A change is not yet visible after one edge.
- R5: When tmr_oc_en[i] is 1, pin i has pad_oe 1 and pad_out equal to tmr_oc_val[i]. This holds on every pin and takes precedence over all other sources.
- R6: On pins 0, 4 and 5, an active pwm_en[i] with no timer override gives pad_oe 1 and pad_out equal to pwm_val[i]. On pins 1, 2, 3, 6 and 7, pwm_en has no effect on pad_oe or pad_out.
- R7: On pin 5 only, clkout_en with no timer or PWM override gives pad_oe 1 and pad_out equal to clkout_val. On every other pin, clkout_en has no effect.
- R8: An override never changes the stored direction or data bits. Reading offset 0x242 during or after an override returns the last written value, and software control resumes with that value when the override is released.
- R9: A read at any offset other than 0x240, 0x241 or 0x242 returns 0. A write to 0x241 or to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 10 | Register offset |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pad_in | input | 8 | Pad input levels |
| tmr_oc_en | input | 8 | Timer output-compare enable per pin |
| tmr_oc_val | input | 8 | Timer output-compare level per pin |
| pwm_en | input | 8 | PWM channel enable per pin (routed on pins 0, 4, 5) |
| pwm_val | input | 8 | PWM level per pin |
| clkout_en | input | 1 | External clock output enable (pin 5) |
| clkout_val | input | 1 | External clock output level |
| pad_out | output | 8 | Pad output level |
| pad_oe | output | 8 | Pad output enable |

## Verification
A corrupted direction or data bit is visible on pad_oe or pad_out in the same cycle, as long as no peripheral holds the pin. Under an override the corruption stays hidden until the pin is released or the register is read back, so the bench reads the direction register both during and after overrides. A wrong priority decision shows up combinationally on the pin concerned. A synchronizer fault shows up as input read data that appears one edge too early or too late.

// File: rtl/gpio_ovr_pkg.sv
// Shared definitions for the overridable GPIO port.
// Assumes an 8-bit port; the routing masks give the pins that each peripheral may claim.
package gpio_ovr_pkg;
    localparam int unsigned PORT_W  = 8;
    localparam int unsigned ADDR_W  = 10;
    localparam logic [ADDR_W-1:0] OFS_DATA = 10'h240;
    localparam logic [ADDR_W-1:0] OFS_IN   = 10'h241;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 10'h242;
    localparam logic [PORT_W-1:0] PWM_ROUTE = 8'b0011_0001;
    localparam logic [PORT_W-1:0] CLK_ROUTE = 8'b0010_0000;

    // Source that currently owns a pin
    typedef enum logic [1:0] {
        SRC_SW  = 2'd0,
        SRC_TMR = 2'd1,
        SRC_PWM = 2'd2,
        SRC_CLK = 2'd3
    } pin_src_e;
endpackage

// File: rtl/gpio_ovr_sync.sv
// Two-flop synchronizer for the pad inputs.
// Assumes pad_in may change at any time relative to clk; the output lags by two edges.
module gpio_ovr_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Shift the pad levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;
endmodule

// File: rtl/gpio_ovr_regs.sv
// Register file: direction and data registers, plus the read mux.
// Assumes single-cycle writes taken at the rising edge and a combinational read path.
module gpio_ovr_regs
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned W  = PORT_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  in_sync,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  data_q
);
    logic hit_dir;
    logic hit_data;
    logic hit_in;

    // Decode the offset
    always_comb begin
        hit_dir  = (addr == AW'(OFS_DIR));
        hit_data = (addr == AW'(OFS_DATA));
        hit_in   = (addr == AW'(OFS_IN));
    end

    // Direction register, writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n)             dir_q <= '0;
        else if (we && hit_dir) dir_q <= wdata;
    end

    // Output data register
    always_ff @(posedge clk) begin
        if (!rst_n)              data_q <= '0;
        else if (we && hit_data) data_q <= wdata;
    end

    // Read mux; unmapped offsets return zero
    always_comb begin
        rdata = '0;
        if (hit_dir)       rdata = dir_q;
        else if (hit_data) rdata = data_q;
        else if (hit_in)   rdata = in_sync;
    end

    // R8: direction bits change only on a write to their own offset
    a_r8_dir_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && hit_dir) |=> $stable(dir_q));
    // R9: data bits change only on a write to their own offset
    a_r9_data_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && hit_data) |=> $stable(data_q));
    // R9: unmapped offsets read as zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_dir || hit_data || hit_in) |-> (rdata == '0));
endmodule

// File: rtl/gpio_ovr_pinmux.sv
// Per-pin owner selection: timer, then PWM, then clock output, then software.
// Assumes the route masks mark which pins each peripheral reaches; unrouted enables are ignored.
module gpio_ovr_pinmux
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned     W         = PORT_W,
    parameter logic [W-1:0]    PWM_MASK  = PWM_ROUTE,
    parameter logic [W-1:0]    CLK_MASK  = CLK_ROUTE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] tmr_en,
    input  logic [W-1:0] tmr_val,
    input  logic [W-1:0] pwm_en,
    input  logic [W-1:0] pwm_val,
    input  logic         ck_en,
    input  logic         ck_val,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic     pwm_ok;
        logic     ck_ok;
        pin_src_e src;

        // Tie unrouted peripherals off for this pin
        if (PWM_MASK[i]) begin : g_pwm
            assign pwm_ok = pwm_en[i];
        end else begin : g_nopwm
            assign pwm_ok = 1'b0;
        end
        if (CLK_MASK[i]) begin : g_ck
            assign ck_ok = ck_en;
        end else begin : g_nock
            assign ck_ok = 1'b0;
        end

        // Pick the owner in fixed priority order
        always_comb begin
            if (tmr_en[i])  src = SRC_TMR;
            else if (pwm_ok) src = SRC_PWM;
            else if (ck_ok)  src = SRC_CLK;
            else             src = SRC_SW;
        end

        // Drive enable and level from the owner
        always_comb begin
            unique case (src)
                SRC_TMR: begin pin_oe[i] = 1'b1;     pin_out[i] = tmr_val[i]; end
                SRC_PWM: begin pin_oe[i] = 1'b1;     pin_out[i] = pwm_val[i]; end
                SRC_CLK: begin pin_oe[i] = 1'b1;     pin_out[i] = ck_val;     end
                default: begin pin_oe[i] = dir_q[i]; pin_out[i] = data_q[i];  end
            endcase
        end

        // R5: an enabled timer channel always owns its pin
        a_r5_timer_wins: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_en[i] |-> (pin_oe[i] && pin_out[i] == tmr_val[i]));
        // R2: a pin that no peripheral holds follows its direction bit
        a_r2_sw_dir: assert property (@(posedge clk) disable iff (!rst_n)
            !(tmr_en[i] || (PWM_MASK[i] && pwm_en[i]) || (CLK_MASK[i] && ck_en))
            |-> (pin_oe[i] == dir_q[i]));
        if (!PWM_MASK[i] && !CLK_MASK[i]) begin : g_chk_plain
            // R6, R7: unrouted pins ignore the PWM and clock enables
            a_r6_unrouted: assert property (@(posedge clk) disable iff (!rst_n)
                !tmr_en[i] |-> (pin_oe[i] == dir_q[i]));
        end
    end
endmodule

// File: rtl/gpio_ovr_port.sv
// Top of the overridable GPIO port: registers, input synchronizer and pin owner selection.
// Assumes a synchronous active-low reset and a single clock domain for the bus and peripherals.
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int unsigned W  = PORT_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pad_in,
    input  logic [W-1:0]  tmr_oc_en,
    input  logic [W-1:0]  tmr_oc_val,
    input  logic [W-1:0]  pwm_en,
    input  logic [W-1:0]  pwm_val,
    input  logic          clkout_en,
    input  logic          clkout_val,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe
);
    logic [W-1:0] in_sync;
    logic [W-1:0] dir_q;
    logic [W-1:0] data_q;

    gpio_ovr_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (in_sync)
    );

    gpio_ovr_regs #(.W(W), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .in_sync (in_sync),
        .rdata   (bus_rdata),
        .dir_q   (dir_q),
        .data_q  (data_q)
    );

    gpio_ovr_pinmux #(.W(W)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_q   (dir_q),
        .data_q  (data_q),
        .tmr_en  (tmr_oc_en),
        .tmr_val (tmr_oc_val),
        .pwm_en  (pwm_en),
        .pwm_val (pwm_val),
        .ck_en   (clkout_en),
        .ck_val  (clkout_val),
        .pin_out (pad_out),
        .pin_oe  (pad_oe)
    );

    // R7: only pin 5 may be held by the clock output alone
    a_r7_clk_pin5_only: assert property (@(posedge clk) disable iff (!rst_n)
        (clkout_en && !tmr_oc_en[5] && !pwm_en[5]) |-> (pad_oe[5] && pad_out[5] == clkout_val));
endmodule

// File: tb/gpio_ovr_port_test.sv
module gpio_ovr_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] tmr_oc_en = '0, tmr_oc_val = '0, pwm_en = '0, pwm_val = '0;
    logic       clkout_en = 1'b0, clkout_val = 1'b0;
    logic [7:0] pad_out, pad_oe;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] m_dir = '0;
    logic [7:0] m_data = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_ovr_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .tmr_oc_en(tmr_oc_en), .tmr_oc_val(tmr_oc_val), .pwm_en(pwm_en),
        .pwm_val(pwm_val), .clkout_en(clkout_en), .clkout_val(clkout_val),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Expected enable per pin from the priority rules
    function automatic logic [7:0] exp_oe();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (tmr_oc_en[i])                                  r[i] = 1'b1;
            else if ((i == 0 || i == 4 || i == 5) && pwm_en[i]) r[i] = 1'b1;
            else if (i == 5 && clkout_en)                       r[i] = 1'b1;
            else                                               r[i] = m_dir[i];
        end
        return r;
    endfunction

    // Expected level per pin; only meaningful where the pin is driven
    function automatic logic [7:0] exp_out();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (tmr_oc_en[i])                                  r[i] = tmr_oc_val[i];
            else if ((i == 0 || i == 4 || i == 5) && pwm_en[i]) r[i] = pwm_val[i];
            else if (i == 5 && clkout_en)                       r[i] = clkout_val;
            else                                               r[i] = m_data[i];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_pins(input string req);
        logic [7:0] oe_e;
        oe_e = exp_oe();
        check({req, " oe"}, pad_oe, oe_e);
        check({req, " out"}, pad_out & oe_e, exp_out() & oe_e);
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == 10'h242) m_dir = d;
        if (a == 10'h240) m_data = d;
    endtask

    task automatic rd_check(input string req, input logic [9:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd1729);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", pad_oe, 8'h00);
        rd_check("R1 dir", 10'h242, 8'h00);
        rd_check("R1 data", 10'h240, 8'h00);

        // R2 / R3 directed
        wr(10'h240, 8'hA5);
        wr(10'h242, 8'h0F);
        rd_check("R2 dir readback", 10'h242, 8'h0F);
        rd_check("R3 data readback", 10'h240, 8'hA5);
        check_pins("R2 R3 sw drive");

        // R9 unmapped reads and writes
        wr(10'h241, 8'hFF);
        wr(10'h243, 8'hFF);
        wr(10'h042, 8'hFF);
        rd_check("R9 unmapped 0x243", 10'h243, 8'h00);
        rd_check("R9 unmapped 0x3FF", 10'h3FF, 8'h00);
        rd_check("R9 dir untouched", 10'h242, 8'h0F);
        rd_check("R9 data untouched", 10'h240, 8'hA5);

        // R4 synchronizer latency
        @(negedge clk);
        pad_in = 8'h3C;
        bus_addr = 10'h241;
        @(posedge clk); #1;
        check("R4 one edge", bus_rdata, 8'h00);
        @(posedge clk); #1;
        check("R4 two edges", bus_rdata, 8'h3C);

        // R5 timer on every pin, dir held
        @(negedge clk);
        tmr_oc_en = 8'hFF; tmr_oc_val = 8'h96;
        pwm_en = 8'hFF; pwm_val = 8'h00; clkout_en = 1'b1; clkout_val = 1'b0;
        #1;
        check_pins("R5 timer all pins");
        rd_check("R8 dir under override", 10'h242, 8'h0F);

        // R6 PWM routed only to 0,4,5
        tmr_oc_en = 8'h00; pwm_val = 8'hFF; clkout_en = 1'b0;
        wr(10'h242, 8'h00);
        check_pins("R6 pwm routing");
        check("R6 unrouted ignored", pad_oe, 8'h31);

        // R7 clock only on pin 5
        pwm_en = 8'h00; clkout_en = 1'b1; clkout_val = 1'b1;
        #1;
        check("R7 clk pin5 oe", pad_oe, 8'h20);
        check("R7 clk pin5 out", pad_out[5] ? 8'h01 : 8'h00, 8'h01);
        tmr_oc_en = 8'h20; tmr_oc_val = 8'h00;
        #1;
        check_pins("R7 timer over clk");

        // R8 release resumes software setting
        wr(10'h242, 8'h81);
        tmr_oc_en = 8'hFF; #1;
        check_pins("R8 held");
        tmr_oc_en = 8'h00; clkout_en = 1'b0; #1;
        check("R8 resume", pad_oe, 8'h81);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int unsigned op;
            op = $urandom_range(0, 4);
            case (op)
                0: wr(10'h242, 8'($urandom));
                1: wr(10'h240, 8'($urandom));
                2: wr(10'($urandom), 8'($urandom));
                default: begin
                    @(negedge clk);
                    tmr_oc_en  = 8'($urandom) & 8'($urandom);
                    tmr_oc_val = 8'($urandom);
                    pwm_en     = 8'($urandom);
                    pwm_val    = 8'($urandom);
                    clkout_en  = 1'($urandom);
                    clkout_val = 1'($urandom);
                end
            endcase
            #1;
            check_pins("R5 R6 R7 random");
            rd_check("R8 random dir", 10'h242, m_dir);
            rd_check("R3 random data", 10'h240, m_data);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule